// File: doc/BRIEF.md
# Interrupt Status Aggregator with Per-Source Clear

This block collects four interrupt sources into one summary register that a microcontroller reads over a small register bus. The four sources are a D-channel HDLC event, a synchronous-transfer event, a change on a 4-bit command/indication (C/I) input, and a transceiver event. Each source also has its own detail register. The summary register only shows that a source has something pending; the processor then reads that source's detail register to find the cause.

Reading the summary register changes nothing. A summary bit clears only when its own detail register is read. An 8-bit mask register can hide any source. A hidden source stays latched and shows up again as soon as its mask bit returns to 0. The interrupt line is high while at least one pending source is unmasked.

The HDLC, synchronous-transfer and transceiver sources each give a one-cycle event pulse with a 4-bit cause. Cause bits pile up in the detail register until that register is read. The C/I source compares its input with the value from the previous cycle. Its detail register holds the most recent value.

Top module: `irq_status_hub`

## Requirements
- R1: After a synchronous reset the mask register is 0xFF, no source is pending, `irq` is 0 and `bus_rdata` is 0.
- R2: A source event sets that source's pending bit at the next clock edge. In the summary register (address 0) the bits are HDLC at bit 0, synchronous transfer at bit 2, C/I at bit 4 and transceiver at bit 6. All other summary bits read as 0.
- R3: A summary bit whose mask bit is 1 reads as 0 but stays pending. It appears on the first summary read after its mask bit is written back to 0. Mask bit positions match the summary bit positions.
- R4: Reading the summary register clears no pending bit.
- R5: Reading a detail register clears only that source's pending bit. The detail registers are HDLC at address 2, synchronous transfer at address 3, C/I at address 4 and transceiver at address 5.
- R6: If a source event arrives in the same cycle as the read of that source's detail register, the pending bit stays set. The detail register then holds only the new cause (for C/I, the new value).
- R7: `irq` is 1 exactly when some pending source has its mask bit at 0. It follows a mask write in the cycle right after the write edge.
- R8: A C/I change is detected whenever `ci_in` differs from its value in the previous cycle; the value before the first cycle is 0. The C/I detail register (address 4) returns the latest value in bits 3:0. Reading it does not change that value.
- R9: Address 1 reads and writes the 8-bit mask. Writes to address 0 or to any detail address have no effect.
- R10: For HDLC, synchronous transfer and transceiver, each event ORs its 4-bit cause into the detail register (bits 3:0; bits 7:4 read 0). A read returns the gathered value and clears it to 0.
- R11: `bus_rdata` takes its new value at the clock edge where `bus_rd` is 1 and holds it otherwise. Reads of addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| hdlc_evt | input | 1 | HDLC event pulse |
| hdlc_cause | input | 4 | HDLC cause bits |
| sync_evt | input | 1 | Synchronous-transfer event pulse |
| sync_cause | input | 4 | Synchronous-transfer cause bits |
| ci_in | input | 4 | C/I value; any change raises the C/I source |
| trx_evt | input | 1 | Transceiver event pulse |
| trx_cause | input | 4 | Transceiver cause bits |
| irq | output | 1 | Interrupt request, active high |

## Verification
The patterns are:
- **Single events, one source at a time.** These fix the summary bit positions and separate each source's clear address from the others.
- **Masked events, read and then unmasked.** These separate "hidden but still pending" from "dropped".
- **Repeated summary reads.** These expose any clear-on-read of the summary.
- **A detail read in the same cycle as a new event.** This separates a lost event from a kept one.
- **Two cause pulses before one read.** These separate accumulation from overwrite.
- **C/I steps that return to an earlier value.** These check that the comparison is against the previous cycle, not against the last value read.

// File: rtl/irq_hub_pkg.sv
`timescale 1ns/1ps
package irq_hub_pkg;
  localparam int unsigned NSRC = 4;

  typedef enum int unsigned {
    SRC_HDLC = 0,
    SRC_SYNC = 1,
    SRC_CI   = 2,
    SRC_TRX  = 3
  } src_e;

  localparam int unsigned ADR_SUM  = 0;
  localparam int unsigned ADR_MASK = 1;
  localparam int unsigned ADR_LAST = 5;

  // bit of source i in the summary and mask registers
  function automatic int unsigned sum_pos(input int unsigned i);
    return 2 * i;
  endfunction

  // detail register address of source i
  function automatic int unsigned det_addr(input int unsigned i);
    return i + 2;
  endfunction
endpackage

// File: rtl/irq_ci_watch.sv
`timescale 1ns/1ps
module irq_ci_watch #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ci_in,
  output logic         chg
);
  logic [W-1:0] ci_q;

  always_ff @(posedge clk) begin
    if (rst) ci_q <= '0;
    else     ci_q <= ci_in;
  end

  assign chg = (ci_in != ci_q);
endmodule

// File: rtl/irq_src_slot.sv
`timescale 1ns/1ps
module irq_src_slot #(
  parameter int unsigned W      = 4,
  parameter bit          STICKY = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         evt,
  input  logic [W-1:0] cause,
  input  logic         clr,
  output logic         pend,
  output logic [W-1:0] detail
);
  logic         pend_q;
  logic [W-1:0] det_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= evt | (pend_q & ~clr);
  end

  generate
    if (STICKY) begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst)      det_q <= '0;
        else if (evt) det_q <= (clr ? '0 : det_q) | cause;
        else if (clr) det_q <= '0;
      end
    end else begin : g_value
      always_ff @(posedge clk) begin
        if (rst)      det_q <= '0;
        else if (evt) det_q <= cause;
      end
    end
  endgenerate

  assign pend   = pend_q;
  assign detail = det_q;
endmodule

// File: rtl/irq_reg_port.sv
`timescale 1ns/1ps
module irq_reg_port
  import irq_hub_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SRC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   pend,
  input  logic [SRC_W-1:0]  det [NSRC],
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] mask,
  output logic [NSRC-1:0]   en,
  output logic [NSRC-1:0]   clr
);
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    if (addr == ADDR_W'(ADR_SUM)) begin
      for (int i = 0; i < NSRC; i++)
        word[sum_pos(i)] = pend[i] & ~mask_q[sum_pos(i)];
    end else if (addr == ADDR_W'(ADR_MASK)) begin
      word = mask_q;
    end else begin
      for (int i = 0; i < NSRC; i++)
        if (addr == ADDR_W'(det_addr(i)))
          word = DATA_W'(det[i]);
    end
  end

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      assign clr[g] = rd & (addr == ADDR_W'(det_addr(g)));
      assign en[g]  = ~mask_q[sum_pos(g)];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      rdata_q <= '0;
    end else begin
      if (wr && addr == ADDR_W'(ADR_MASK)) mask_q <= wdata;
      if (rd) rdata_q <= word;
    end
  end

  assign rdata = rdata_q;
  assign mask  = mask_q;
endmodule

// File: rtl/irq_status_hub.sv
`timescale 1ns/1ps
module irq_status_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SRC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              hdlc_evt,
  input  logic [SRC_W-1:0]  hdlc_cause,
  input  logic              sync_evt,
  input  logic [SRC_W-1:0]  sync_cause,
  input  logic [SRC_W-1:0]  ci_in,
  input  logic              trx_evt,
  input  logic [SRC_W-1:0]  trx_cause,
  output logic              irq
);
  logic [NSRC-1:0]   evt_v;
  logic [NSRC-1:0]   pend_v;
  logic [NSRC-1:0]   clr_v;
  logic [NSRC-1:0]   en_v;
  logic [SRC_W-1:0]  cause_a [NSRC];
  logic [SRC_W-1:0]  det_a   [NSRC];
  logic [DATA_W-1:0] mask_q;
  logic              ci_chg;

  irq_ci_watch #(.W(SRC_W)) u_ci (
    .clk   (clk),
    .rst   (rst),
    .ci_in (ci_in),
    .chg   (ci_chg)
  );

  assign evt_v[SRC_HDLC]   = hdlc_evt;
  assign evt_v[SRC_SYNC]   = sync_evt;
  assign evt_v[SRC_CI]     = ci_chg;
  assign evt_v[SRC_TRX]    = trx_evt;
  assign cause_a[SRC_HDLC] = hdlc_cause;
  assign cause_a[SRC_SYNC] = sync_cause;
  assign cause_a[SRC_CI]   = ci_in;
  assign cause_a[SRC_TRX]  = trx_cause;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_slot
      irq_src_slot #(
        .W      (SRC_W),
        .STICKY (g != SRC_CI)
      ) u_slot (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt_v[g]),
        .cause  (cause_a[g]),
        .clr    (clr_v[g]),
        .pend   (pend_v[g]),
        .detail (det_a[g])
      );
    end
  endgenerate

  irq_reg_port #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SRC_W  (SRC_W)
  ) u_port (
    .clk   (clk),
    .rst   (rst),
    .addr  (bus_addr),
    .wr    (bus_wr),
    .rd    (bus_rd),
    .wdata (bus_wdata),
    .pend  (pend_v),
    .det   (det_a),
    .rdata (bus_rdata),
    .mask  (mask_q),
    .en    (en_v),
    .clr   (clr_v)
  );

  assign irq = |(pend_v & en_v);
endmodule

// File: rtl/irq_status_hub_chk.sv
`timescale 1ns/1ps
module irq_status_hub_chk
  import irq_hub_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [NSRC-1:0]   pend,
  input logic [NSRC-1:0]   evt,
  input logic [NSRC-1:0]   clr,
  input logic [DATA_W-1:0] mask
);
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && pend == '0 && &mask && bus_rdata == '0));

  p_event_latches_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(evt) & ~pend) == '0));

  p_mask_hides_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(ADR_SUM)) |=> ((bus_rdata & $past(mask)) == '0));

  p_summary_read_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(ADR_SUM)) |=> (($past(pend) & ~pend) == '0));

  p_clear_needs_read_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(pend) & ~pend & ~$past(clr)) == '0));

  p_event_wins_r6: assert property (@(posedge clk) disable iff (rst)
    ((evt & clr) != '0) |=> (($past(evt & clr) & ~pend) == '0));

  p_irq_needs_pending_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> (pend != '0));

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr > ADDR_W'(ADR_LAST)) |=> (bus_rdata == '0));
endmodule

bind irq_status_hub irq_status_hub_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .pend      (pend_v),
  .evt       (evt_v),
  .clr       (clr_v),
  .mask      (mask_q)
);

// File: tb/test_irq_status_hub.sv
`timescale 1ns/1ps
module test_irq_status_hub;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       hdlc_evt = 1'b0, sync_evt = 1'b0, trx_evt = 1'b0;
  logic [3:0] hdlc_cause = '0, sync_cause = '0, trx_cause = '0, ci_in = '0;
  logic       irq;

  int    n_cmp = 0, n_bad = 0;
  bit    started = 1'b0;
  string cur = "R1";

  bit [3:0] mp;
  bit [7:0] mm;
  bit [3:0] md [4];
  bit [3:0] mprev;
  bit [7:0] mr;

  always #2.5 clk = ~clk;

  irq_status_hub i_irq_status_hub (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hdlc_evt(hdlc_evt),
    .hdlc_cause(hdlc_cause), .sync_evt(sync_evt), .sync_cause(sync_cause),
    .ci_in(ci_in), .trx_evt(trx_evt), .trx_cause(trx_cause), .irq(irq)
  );

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    bit [7:0] w;
    bit [3:0] ev, cl;
    bit [3:0] cz [4];
    if (rst) begin
      mp = '0; mm = 8'hFF; mprev = '0; mr = '0;
      for (int i = 0; i < 4; i++) md[i] = '0;
    end else begin
      w = '0;
      case (bus_addr)
        3'd0: for (int i = 0; i < 4; i++) w[2*i] = mp[i] & ~mm[2*i];
        3'd1: w = mm;
        3'd2: w = {4'h0, md[0]};
        3'd3: w = {4'h0, md[1]};
        3'd4: w = {4'h0, md[2]};
        3'd5: w = {4'h0, md[3]};
        default: w = '0;
      endcase
      ev = {trx_evt, ci_in != mprev, sync_evt, hdlc_evt};
      cl = bus_rd ? {bus_addr == 3'd5, bus_addr == 3'd4, bus_addr == 3'd3, bus_addr == 3'd2} : 4'h0;
      cz[0] = hdlc_cause; cz[1] = sync_cause; cz[2] = ci_in; cz[3] = trx_cause;
      for (int i = 0; i < 4; i++) begin
        mp[i] = ev[i] | (mp[i] & ~cl[i]);
        if (i == 2) begin
          if (ev[i]) md[i] = cz[i];
        end else begin
          md[i] = (cl[i] ? 4'h0 : md[i]) | (ev[i] ? cz[i] : 4'h0);
        end
      end
      mprev = ci_in;
      if (bus_wr && bus_addr == 3'd1) mm = bus_wdata;
      if (bus_rd) mr = w;
    end
  end

  always @(negedge clk) begin
    bit exp_irq;
    if (started) begin
      exp_irq = |(mp & {~mm[6], ~mm[4], ~mm[2], ~mm[0]});
      n_cmp++;
      if (bus_rdata !== mr) begin
        n_bad++;
        $display("FAIL %s bus_rdata actual=%02h expected=%02h", cur, bus_rdata, mr);
      end
      n_cmp++;
      if (irq !== exp_irq) begin
        n_bad++;
        $display("FAIL %s irq actual=%0b expected=%0b", cur, irq, exp_irq);
      end
    end
  end

  task automatic rd(input logic [2:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wrr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic ev(input int s, input logic [3:0] c);
    @(negedge clk);
    case (s)
      0: begin hdlc_evt = 1'b1; hdlc_cause = c; end
      1: begin sync_evt = 1'b1; sync_cause = c; end
      default: begin trx_evt = 1'b1; trx_cause = c; end
    endcase
    @(negedge clk);
    hdlc_evt = 1'b0; sync_evt = 1'b0; trx_evt = 1'b0;
  endtask

  task automatic done();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL %s watchdog expired", cur);
    done();
  end

  initial begin
    repeat (3) @(negedge clk);
    started = 1'b1;
    @(negedge clk); rst = 1'b0;
    cur = "R1"; rd(3'd1); rd(3'd0);
    cur = "R9"; wrr(3'd1, 8'h00); rd(3'd1);
    cur = "R2"; ev(0, 4'h3); rd(3'd0); ev(1, 4'h1); rd(3'd0); ev(2, 4'h8); rd(3'd0);
    cur = "R8"; @(negedge clk); ci_in = 4'h5; rd(3'd0); rd(3'd4);
    cur = "R4"; rd(3'd0); rd(3'd0);
    cur = "R5"; rd(3'd2); rd(3'd0); rd(3'd4); rd(3'd0); rd(3'd3); rd(3'd5); rd(3'd0);
    cur = "R10"; ev(1, 4'h1); ev(1, 4'h4); rd(3'd3); rd(3'd3); rd(3'd0);
    cur = "R3"; wrr(3'd1, 8'h40); ev(2, 4'h2); rd(3'd0); rd(3'd0);
    wrr(3'd1, 8'h00); rd(3'd0); rd(3'd5);
    cur = "R7"; wrr(3'd1, 8'hFF); ev(0, 4'h1); wrr(3'd1, 8'hFE); wrr(3'd1, 8'hFF); rd(3'd2);
    cur = "R6";
    wrr(3'd1, 8'h00);
    ev(0, 4'h2);
    @(negedge clk); bus_addr = 3'd2; bus_rd = 1'b1; hdlc_evt = 1'b1; hdlc_cause = 4'h8;
    @(negedge clk); bus_rd = 1'b0; hdlc_evt = 1'b0;
    rd(3'd0); rd(3'd2); rd(3'd0);
    @(negedge clk); ci_in = 4'h9; bus_addr = 3'd4; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    rd(3'd0); rd(3'd4);
    cur = "R8"; @(negedge clk); ci_in = 4'h5; @(negedge clk); ci_in = 4'h9;
    rd(3'd4); rd(3'd4); rd(3'd0);
    cur = "R9"; wrr(3'd0, 8'hFF); wrr(3'd3, 8'hFF); rd(3'd0); rd(3'd3); rd(3'd1);
    cur = "R11"; rd(3'd6); @(negedge clk); @(negedge clk); rd(3'd7); rd(3'd1); rd(3'd7);
    cur = "R1"; @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0; rd(3'd1); rd(3'd4);
    repeat (2) @(negedge clk);
    done();
  end
endmodule